// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a fast-mode I2C target that gives an external host byte-wide access to a small bank of control and status registers inside a chip. It watches the SCL and SDA lines through synchronisers and glitch filters running on a system clock at least ten times faster than SCL. It recognises START, repeated START and STOP conditions and answers to a 7-bit device address whose lowest bit comes from a strap pin. Each transaction carries a register pointer byte, followed either by one data byte to store or by a repeated START and a read of one byte.

The register file holds `NUM_REGS` eight-bit locations selected by the low six bits of the pointer. Most are read/write and appear on a flat control output. A window of `RO_NUM` locations starting at `RO_BASE` is read-only and mirrors a status input. Any pointer at or above `NUM_REGS` selects nothing: it reads as zero and ignores writes. The block only pulls SDA low and never holds SCL, so it never stretches the clock.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The block acknowledges a device address byte whose upper seven bits equal 1110000 when `addr_sel` is 0, or 1110001 when `addr_sel` is 1. It does not acknowledge any other value.
- R2: The eighth bit of the address byte picks the direction: 0 for write and 1 for read. A read that follows a START directly, with no pointer byte, returns the register at the pointer left by the last transaction.
- R3: Only bits 5:0 of the pointer byte select a register. Bits 7:6 have no effect.
- R4: In a write frame (START, address with bit 0 = 0, pointer, data, STOP) all three bytes are acknowledged. The data byte is stored at the pointer and shows on `ctrl_q[8*p +: 8]`.
- R5: In a read frame (START, address+W, pointer, repeated START, address+R) the block sends the selected byte MSB first. It then releases SDA during the master's ninth clock. SDA changes only after SCL has been seen low.
- R6: Pointers 34 to 63 read as 0x00. Writes to them are acknowledged and change no register.
- R7: Pointers 0x10 to 0x13 read bytes 0 to 3 of `stat_d`, where byte k is `stat_d[8k +: 8]`. Writes to them are acknowledged and ignored, and their `ctrl_q` slices stay 0.
- R8: The recovery sequence (START, nine clocks with SDA released, repeated START, STOP) returns the block to idle. It leaves all register contents unchanged, and the next frame works normally.
- R9: After an address that does not match, the block drives SDA for no later byte until the next START. It also changes neither the pointer nor any register.
- R10: After reset SDA is released and every read/write register holds 0x00.
- R11: A write frame stores only one byte. A second data byte in the same frame is not acknowledged and not stored.
- R12: SDA is released on the cycle after every STOP condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that sets the device address LSB |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| stat_d | input | RO_NUM*8 | Status bytes shown in the read-only window |
| ctrl_q | output | NUM_REGS*8 | All register contents, byte p at bits 8p+7:8p |

## Verification
The assertions assume that SCL and SDA hold each new level for longer than the glitch filter. They also assume that SDA moves only while SCL is low, except for START and STOP. Under those conditions every SDA drive change of the block follows a filtered SCL fall or a bus condition. The bench master drives one bit every 40 system cycles. It moves SDA a quarter period after SCL falls, well after the block's filtered fall, and it samples SDA in the middle of the SCL high phase. Because of this, no edge of the bench races the synchroniser delay.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int PTR_W = 6;
    localparam logic [5:0] DEV_PREFIX = 6'b111000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_PTR,
        ST_PTRACK,
        ST_WDAT,
        ST_WACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } eng_state_e;

    typedef enum logic [1:0] {
        RK_RW,
        RK_RO,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_match(input logic [6:0] a, input logic sel);
        return a == {DEV_PREFIX, sel};
    endfunction

    function automatic reg_kind_e reg_kind(input int idx, input int num,
                                           input int ro_base, input int ro_num);
        if (idx >= num)
            return RK_NONE;
        else if (idx >= ro_base && idx < ro_base + ro_num)
            return RK_RO;
        else
            return RK_RW;
    endfunction

endpackage

// File: rtl/i2c_rb_cond.sv
module i2c_rb_cond
    import i2c_rb_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0] raw;
    logic [1:0] filt;
    logic [1:0] prev;

    assign raw = {scl_i, sda_i};

    // line 1 = SCL, line 0 = SDA; each: two-flop sync then stability filter
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                sync    <= 2'b11;
                cnt     <= '0;
                filt[g] <= 1'b1;
                prev[g] <= 1'b1;
            end else begin
                sync    <= {sync[0], raw[g]};
                prev[g] <= filt[g];
                if (sync[1] == filt[g]) begin
                    cnt <= '0;
                end else if (cnt == CW'(FILT_LEN - 1)) begin
                    filt[g] <= sync[1];
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        evt.scl_rise = ~prev[1] & filt[1];
        evt.scl_fall = prev[1] & ~filt[1];
        evt.start    = prev[1] & filt[1] & prev[0] & ~filt[0];
        evt.stop     = prev[1] & filt[1] & ~prev[0] & filt[0];
        evt.sda      = filt[0];
    end

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
    import i2c_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             addr_sel,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    eng_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            is_rd   <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_DEVADR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADR, ST_PTR, ST_WDAT: begin
                        if (evt.scl_rise) begin
                            shreg <= {shreg[6:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == ST_DEVADR) begin
                                if (dev_match(shreg[7:1], addr_sel)) begin
                                    is_rd  <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_DEVACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= shreg[PTR_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_PTRACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= shreg;
                                sda_oe  <= 1'b1;
                                state   <= ST_WACK;
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (is_rd) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_PTR;
                            end
                        end
                    end
                    ST_PTRACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_WACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_SKIP;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TXACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (evt.scl_rise)
                            state <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA drive only moves after a filtered SCL fall or a bus condition
    assert_sda_moves_low_scl_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(evt.scl_fall || evt.stop || evt.start));

    assert_stop_releases_R12: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_oe);

    assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe);

    assert_write_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(evt.scl_fall));

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
    import i2c_rb_pkg::*;
#(
    parameter int NUM_REGS = 34,
    parameter int RO_BASE  = 16,
    parameter int RO_NUM   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    input  logic [RO_NUM*8-1:0]   stat_d,
    output logic [NUM_REGS*8-1:0] ctrl_q
);
    logic [7:0] view [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (reg_kind(i, NUM_REGS, RO_BASE, RO_NUM) == RK_RO) begin : g_ro
            assign ctrl_q[i*8 +: 8] = '0;
            assign view[i]          = stat_d[(i-RO_BASE)*8 +: 8];
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_en && wr_addr == PTR_W'(i))
                    q <= wr_data;
            end
            assign ctrl_q[i*8 +: 8] = q;
            assign view[i]          = q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == PTR_W'(i))
                rd_data = view[i];
    end

    reg_kind_e wkind;
    assign wkind = reg_kind(int'(wr_addr), NUM_REGS, RO_BASE, RO_NUM);

    assert_unimpl_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wkind == RK_NONE) |=> $stable(ctrl_q));

    assert_ro_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wkind == RK_RO) |=> $stable(ctrl_q));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter int NUM_REGS = 34,
    parameter int RO_BASE  = 16,
    parameter int RO_NUM   = 4,
    parameter int FILT_LEN = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  addr_sel,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [RO_NUM*8-1:0]   stat_d,
    output logic [NUM_REGS*8-1:0] ctrl_q
);
    bus_evt_t         evt;
    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    i2c_rb_cond #(.FILT_LEN(FILT_LEN)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_rb_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe)
    );

    i2c_rb_regs #(
        .NUM_REGS (NUM_REGS),
        .RO_BASE  (RO_BASE),
        .RO_NUM   (RO_NUM)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .stat_d  (stat_d),
        .ctrl_q  (ctrl_q)
    );

endmodule

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
    localparam int NUM_REGS = 34;
    localparam int RO_NUM   = 4;
    localparam int Q        = 10;

    typedef struct packed {
        logic       rd;
        logic [6:0] dev;
        logic [7:0] regb;
        logic [7:0] dat;
        logic       ack;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h71, 8'h05, 8'h3C, 1'b1, 8'd4},   // R4 write
        '{1'b1, 7'h71, 8'h05, 8'h3C, 1'b1, 8'd5},   // R5 read back
        '{1'b0, 7'h71, 8'hC7, 8'h96, 1'b1, 8'd3},   // R3 top bits set
        '{1'b1, 7'h71, 8'h07, 8'h96, 1'b1, 8'd3},   // R3
        '{1'b1, 7'h71, 8'h47, 8'h96, 1'b1, 8'd3},   // R3
        '{1'b0, 7'h71, 8'h21, 8'hF0, 1'b1, 8'd4},   // R4 last register
        '{1'b1, 7'h71, 8'h21, 8'hF0, 1'b1, 8'd4},   // R4
        '{1'b0, 7'h71, 8'h22, 8'h55, 1'b1, 8'd6},   // R6 write to hole
        '{1'b1, 7'h71, 8'h22, 8'h00, 1'b1, 8'd6},   // R6
        '{1'b1, 7'h71, 8'h3F, 8'h00, 1'b1, 8'd6},   // R6
        '{1'b1, 7'h71, 8'h10, 8'h3C, 1'b1, 8'd7},   // R7 status byte 0
        '{1'b0, 7'h71, 8'h12, 8'hFF, 1'b1, 8'd7},   // R7 write ignored
        '{1'b1, 7'h71, 8'h12, 8'hC3, 1'b1, 8'd7},   // R7
        '{1'b0, 7'h70, 8'h05, 8'h00, 1'b0, 8'd1},   // R1 wrong LSB
        '{1'b1, 7'h71, 8'h05, 8'h3C, 1'b1, 8'd9},   // R9 untouched
        '{1'b0, 7'h31, 8'h05, 8'h11, 1'b0, 8'd1},   // R1 wrong prefix
        '{1'b1, 7'h71, 8'h00, 8'h00, 1'b1, 8'd10}   // R10 reset value
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_sel = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [RO_NUM*8-1:0]   stat_d = 32'hA5C35A3C;
    logic [NUM_REGS*8-1:0] ctrl_q;
    logic [NUM_REGS*8-1:0] saved;
    int checks = 0;
    int errors = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_regbank_slave uut (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .stat_d   (stat_d),
        .ctrl_q   (ctrl_q)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
        end
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(4*Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        seen = sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] d, output logic ninth);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(nack, s);
        ninth = s;
    endtask

    task automatic wr_frame(input logic [6:0] dev, input logic [7:0] rb, input logic [7:0] dat,
                            output logic a1, output logic a2, output logic a3);
        bus_start();
        put_byte({dev, 1'b0}, a1);
        put_byte(rb, a2);
        put_byte(dat, a3);
        bus_stop();
    endtask

    task automatic rd_frame(input logic [6:0] dev, input logic [7:0] rb,
                            output logic a1, output logic a2, output logic a3,
                            output logic [7:0] d, output logic ninth);
        bus_start();
        put_byte({dev, 1'b0}, a1);
        put_byte(rb, a2);
        bus_start();
        put_byte({dev, 1'b1}, a3);
        get_byte(1'b1, d, ninth);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a1, a2, a3, a4, ninth;
        logic [7:0] d;
        string tag;

        tick(5);
        rst = 1'b0;
        tick(5);
        // R10: released bus and cleared registers after reset
        check8("R10 sda", {7'b0, sda_oe}, 8'h00);
        check8("R10 regs", {7'b0, (ctrl_q == '0)}, 8'h01);

        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            if (!VECS[v].rd) begin
                wr_frame(VECS[v].dev, VECS[v].regb, VECS[v].dat, a1, a2, a3);
                check8({tag, " ack-addr"}, {7'b0, a1}, {7'b0, VECS[v].ack});
                check8({tag, " ack-ptr"},  {7'b0, a2}, {7'b0, VECS[v].ack});
                check8({tag, " ack-data"}, {7'b0, a3}, {7'b0, VECS[v].ack});
            end else begin
                rd_frame(VECS[v].dev, VECS[v].regb, a1, a2, a3, d, ninth);
                check8({tag, " acks"}, {5'b0, a1, a2, a3}, 8'h07);
                check8({tag, " data"}, d, VECS[v].dat);
                check8({tag, " ninth"}, {7'b0, ninth}, 8'h01);
            end
        end

        // R4: written values visible on the control output
        check8("R4 ctrl 05", ctrl_q[5*8 +: 8], 8'h3C);
        check8("R4 ctrl 21", ctrl_q[33*8 +: 8], 8'hF0);
        // R7: read-only slot slice stays zero
        check8("R7 ctrl 12", ctrl_q[18*8 +: 8], 8'h00);
        // R12: released after STOP
        check8("R12 sda idle", {7'b0, sda_oe}, 8'h00);

        // R2: direct read uses the pointer of the previous frame
        wr_frame(7'h71, 8'h09, 8'hA7, a1, a2, a3);
        bus_start();
        put_byte(8'hE3, a1);
        get_byte(1'b1, d, ninth);
        bus_stop();
        check8("R2 ack", {7'b0, a1}, 8'h01);
        check8("R2 data", d, 8'hA7);

        // R11: second data byte rejected
        bus_start();
        put_byte(8'hE2, a1);
        put_byte(8'h0A, a2);
        put_byte(8'h12, a3);
        put_byte(8'h34, a4);
        bus_stop();
        check8("R11 acks", {4'b0, a1, a2, a3, a4}, 8'h0E);
        check8("R11 stored", ctrl_q[10*8 +: 8], 8'h12);

        // R8: recovery sequence
        saved = ctrl_q;
        bus_start();
        for (int i = 0; i < 9; i++) clk_bit(1'b1, a1);
        bus_start();
        bus_stop();
        check8("R8 regs kept", {7'b0, (ctrl_q == saved)}, 8'h01);
        check8("R12 sda after recovery", {7'b0, sda_oe}, 8'h00);
        rd_frame(7'h71, 8'h05, a1, a2, a3, d, ninth);
        check8("R8 next read", d, 8'h3C);

        // R1: strap low selects 1110000
        addr_sel = 1'b0;
        tick(Q);
        wr_frame(7'h70, 8'h0B, 8'h5E, a1, a2, a3);
        check8("R1 strap0 acks", {5'b0, a1, a2, a3}, 8'h07);
        wr_frame(7'h71, 8'h0B, 8'h00, a1, a2, a3);
        check8("R1 strap0 reject", {5'b0, a1, a2, a3}, 8'h00);
        rd_frame(7'h70, 8'h0B, a1, a2, a3, d, ninth);
        check8("R9 reg kept", d, 8'h5E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule